// File: doc/BRIEF.md
# Byte Queue with Sticky Error Flags

This block is a first-in, first-out byte queue intended to buffer traffic between a serial transceiver and the logic that consumes or produces its bytes. The depth is a power of two chosen by a parameter. The oldest stored byte is always visible on the head output with no read latency. A read strobe discards that byte, and the next one then becomes visible. A write strobe appends a byte at the tail. Both strobes may be asserted in the same cycle.

The queue reports how many bytes it holds and whether it holds any at all. Two error flags record misuse. One is set by a write that arrives while the queue is full. The other is set by a read that arrives while the queue is empty. Both flags stay set until they are cleared. There are two ways to clear them. A full reset empties the queue and clears both flags. A separate flag-clear input clears only the flags and leaves the stored bytes and the count untouched.

Top module: `byte_queue_sticky`

## Requirements
- R1: While `rst` is high at a rising clock edge, the queue becomes empty: after that edge `level` is 0, `has_data` is 0, `ovf_flag` and `udf_flag` are 0, and `head_byte` is 0.
- R2: Bytes leave in the order they were written. The oldest stored byte is on `head_byte` from the edge that stores it (when the queue was empty), with no read needed. `head_byte` only changes on an edge where `rd_next` removes a byte or where `rst` is high.
- R3: `has_data` is 1 exactly when `level` is at least 1.
- R4: If `wr_en` is high, `rd_next` is low and `level` equals the depth, then the byte is dropped, the stored bytes and `level` are unchanged, and `ovf_flag` is 1 after the edge.
- R5: If `rd_next` is high while `level` is 0, then `udf_flag` is 1 after the edge and no byte is removed. A `wr_en` in the same cycle still stores its byte, so `level` becomes 1.
- R6: Once set, `ovf_flag` and `udf_flag` stay at 1 until an edge with `rst` high, or an edge with `clr_flags` high and no new event of that kind. When an event and `clr_flags` occur at the same edge, the flag stays set.
- R7: `clr_flags` has no effect on `level`, `has_data` or `head_byte`.
- R8: `level` equals the number of stored bytes. Its range is 0 to the depth (2**ADDR_W), and it is `ADDR_W+1` bits wide.
- R9: If `wr_en` and `rd_next` are both high while `level` is at least 1 (including when the queue is full), one byte is removed and one byte is appended. `level` stays the same, the order is kept, and `ovf_flag` is not set.
- R10: While `level` is 0, `head_byte` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous full reset, active high |
| clr_flags | input | 1 | Clears both error flags and keeps the stored data |
| wr_en | input | 1 | Append `wr_byte` at the tail |
| wr_byte | input | DATA_W | Byte to append |
| rd_next | input | 1 | Discard the head byte and advance |
| head_byte | output | DATA_W | Oldest stored byte, or 0 when empty |
| has_data | output | 1 | High when at least one byte is stored |
| level | output | ADDR_W+1 | Number of stored bytes |
| ovf_flag | output | 1 | Sticky: a write was attempted while full |
| udf_flag | output | 1 | Sticky: a read was attempted while empty |

## Verification
The bench first fills the queue to every level from empty to full. At each level it applies a lone write, a lone read, and a combined read and write, and then drains the queue. This separates the full-queue overflow and empty-queue underflow boundaries from the ordinary push, pop and steady-count paths, and the drain confirms that ordering survives each boundary. Dedicated sequences then test that the flags persist, that a clear arriving together with a new event leaves the flag set, and that a clear alone leaves the data untouched. A long pseudo-random stream of writes, reads, clears and occasional resets follows. It is biased first toward filling and then toward draining, so the flag and count logic are exercised under traffic interleavings that the sweep does not produce.

// File: rtl/bq_pkg.sv
package bq_pkg;

   // Per-cycle decision taken from the strobes and the occupancy.
   typedef struct packed {
      logic push_ok;   // byte is stored this edge
      logic pop_ok;    // head byte is removed this edge
      logic ovf_ev;    // write refused because the queue is full
      logic udf_ev;    // read refused because the queue is empty
   } bq_ctl_t;

   // Upper bound on the address width accepted by the library.
   localparam int unsigned BQ_MAX_ADDR_W = 10;

endpackage

// File: rtl/bq_ctrl.sv
module bq_ctrl
   import bq_pkg::*;
(
   input  logic    wr_en,
   input  logic    rd_next,
   input  logic    is_full,
   input  logic    is_empty,
   output bq_ctl_t ctl
);

   always_comb begin
      ctl        = '0;
      // A read on an empty queue is refused and leaves the pointers alone.
      ctl.pop_ok = rd_next & ~is_empty;
      ctl.udf_ev = rd_next &  is_empty;
      // A write into a full queue is still accepted when a read frees a slot in the same cycle.
      ctl.push_ok = wr_en & (~is_full | rd_next);
      ctl.ovf_ev  = wr_en &   is_full & ~rd_next;
   end

endmodule

// File: rtl/bq_ptrs.sv
module bq_ptrs #(
   parameter int unsigned ADDR_W  = 3,
   localparam int unsigned LVL_W  = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push,
   input  logic              pop,
   output logic [ADDR_W-1:0] wr_ptr,
   output logic [ADDR_W-1:0] rd_ptr,
   output logic [LVL_W-1:0]  count
);

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         // The pointers wrap on their own because the depth is a power of two.
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/bq_store.sv
module bq_store #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 3,
   parameter bit          ZERO_WHEN_EMPTY = 1'b1,
   localparam int unsigned DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   input  logic              head_valid,
   output logic [DATA_W-1:0] head
);

   logic [DATA_W-1:0] slot [DEPTH];

   // One register bank per entry, each with its own decoded write enable.
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (we && (waddr == ADDR_W'(i))) slot[i] <= wdata;
      end
   end

   logic [DATA_W-1:0] raw_head;
   assign raw_head = slot[raddr];

   // The parameter chooses between masking the head to zero and passing the stale entry through.
   if (ZERO_WHEN_EMPTY) begin : g_masked
      assign head = head_valid ? raw_head : '0;
   end else begin : g_raw
      logic unused_valid;
      assign unused_valid = head_valid;
      assign head = raw_head;
   end

endmodule

// File: rtl/bq_flags.sv
module bq_flags (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic ovf_ev,
   input  logic udf_ev,
   output logic ovf,
   output logic udf
);

   // A new event takes priority over a clear in the same cycle.
   always_ff @(posedge clk) begin
      if (rst) begin
         ovf <= 1'b0;
         udf <= 1'b0;
      end else begin
         ovf <= ovf_ev | (ovf & ~clr);
         udf <= udf_ev | (udf & ~clr);
      end
   end

endmodule

// File: rtl/byte_queue_sticky.sv
module byte_queue_sticky
   import bq_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 3,
   parameter bit          ZERO_WHEN_EMPTY = 1'b1,
   localparam int unsigned DEPTH = 1 << ADDR_W,
   localparam int unsigned LVL_W = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr_flags,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic              rd_next,
   output logic [DATA_W-1:0] head_byte,
   output logic              has_data,
   output logic [LVL_W-1:0]  level,
   output logic              ovf_flag,
   output logic              udf_flag
);

   if (DATA_W < 1) begin : g_bad_data_w
      $error("byte_queue_sticky: DATA_W must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > BQ_MAX_ADDR_W) begin : g_bad_addr_w
      $error("byte_queue_sticky: ADDR_W out of range");
   end

   logic [ADDR_W-1:0] wr_ptr;
   logic [ADDR_W-1:0] rd_ptr;
   logic [LVL_W-1:0]  count;
   logic              is_full;
   logic              is_empty;
   bq_ctl_t           ctl;

   assign is_full  = (count == LVL_W'(DEPTH));
   assign is_empty = (count == '0);

   bq_ctrl u_ctrl (
      .wr_en    (wr_en),
      .rd_next  (rd_next),
      .is_full  (is_full),
      .is_empty (is_empty),
      .ctl      (ctl)
   );

   bq_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
      .clk    (clk),
      .rst    (rst),
      .push   (ctl.push_ok),
      .pop    (ctl.pop_ok),
      .wr_ptr (wr_ptr),
      .rd_ptr (rd_ptr),
      .count  (count)
   );

   bq_store #(
      .DATA_W          (DATA_W),
      .ADDR_W          (ADDR_W),
      .ZERO_WHEN_EMPTY (ZERO_WHEN_EMPTY)
   ) u_store (
      .clk        (clk),
      .we         (ctl.push_ok),
      .waddr      (wr_ptr),
      .wdata      (wr_byte),
      .raddr      (rd_ptr),
      .head_valid (~is_empty),
      .head       (head_byte)
   );

   bq_flags u_flags (
      .clk    (clk),
      .rst    (rst),
      .clr    (clr_flags),
      .ovf_ev (ctl.ovf_ev),
      .udf_ev (ctl.udf_ev),
      .ovf    (ovf_flag),
      .udf    (udf_flag)
   );

   assign level    = count;
   assign has_data = ~is_empty;

endmodule

// File: rtl/bq_checker.sv
module bq_checker #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 3,
   localparam int unsigned DEPTH = 1 << ADDR_W,
   localparam int unsigned LVL_W = ADDR_W + 1
) (
   input logic              clk,
   input logic              rst,
   input logic              clr_flags,
   input logic              wr_en,
   input logic              rd_next,
   input logic [DATA_W-1:0] head_byte,
   input logic              has_data,
   input logic [LVL_W-1:0]  level,
   input logic              ovf_flag,
   input logic              udf_flag
);

   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (level == '0 && !has_data && !ovf_flag && !udf_flag));

   assert_head_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (!rd_next && level != '0) |=> $stable(head_byte));

   assert_overflow_drop_R4: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !rd_next && level == LVL_W'(DEPTH)) |=> (ovf_flag && level == LVL_W'(DEPTH)));

   assert_underflow_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (rd_next && !wr_en && level == '0) |=> (udf_flag && level == '0));

   assert_sticky_ovf_R6: assert property (@(posedge clk) disable iff (rst)
      (ovf_flag && !clr_flags) |=> ovf_flag);

   assert_sticky_udf_R6: assert property (@(posedge clk) disable iff (rst)
      (udf_flag && !clr_flags) |=> udf_flag);

   assert_clr_keeps_level_R7: assert property (@(posedge clk) disable iff (rst)
      (clr_flags && !wr_en && !rd_next) |=> (level == $past(level)));

   assert_level_bound_R8: assert property (@(posedge clk) disable iff (rst)
      level <= LVL_W'(DEPTH));

   assert_both_level_R9: assert property (@(posedge clk) disable iff (rst)
      (wr_en && rd_next && level != '0) |=> (level == $past(level)));

   assert_empty_head_zero_R10: assert property (@(posedge clk) disable iff (rst)
      (level == '0) |-> (head_byte == '0));

endmodule

bind byte_queue_sticky bq_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bq_checker (
   .clk       (clk),
   .rst       (rst),
   .clr_flags (clr_flags),
   .wr_en     (wr_en),
   .rd_next   (rd_next),
   .head_byte (head_byte),
   .has_data  (has_data),
   .level     (level),
   .ovf_flag  (ovf_flag),
   .udf_flag  (udf_flag)
);

// File: tb/byte_queue_sticky_tb_top.sv
module byte_queue_sticky_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DW    = 8;
   localparam int AW    = 3;
   localparam int DEPTH = 1 << AW;
   localparam int WATCHDOG_CYCLES = 100000;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          clr_flags = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_byte = '0;
   logic          rd_next = 1'b0;
   logic [DW-1:0] head_byte;
   logic          has_data;
   logic [AW:0]   level;
   logic          ovf_flag;
   logic          udf_flag;

   int checks = 0;
   int errors = 0;

   logic [DW-1:0] mq[$];
   logic m_ovf = 1'b0;
   logic m_udf = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   byte_queue_sticky #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
      .clk       (clk),
      .rst       (rst),
      .clr_flags (clr_flags),
      .wr_en     (wr_en),
      .wr_byte   (wr_byte),
      .rd_next   (rd_next),
      .head_byte (head_byte),
      .has_data  (has_data),
      .level     (level),
      .ovf_flag  (ovf_flag),
      .udf_flag  (udf_flag)
   );

   // Reference queue updated with the values present at the edge.
   task automatic step(input logic r, input logic c, input logic w, input logic [DW-1:0] d, input logic rd);
      logic full, empty, ovf_ev, udf_ev;
      @(negedge clk);
      rst = r; clr_flags = c; wr_en = w; wr_byte = d; rd_next = rd;
      @(posedge clk);
      if (r) begin
         mq.delete(); m_ovf = 1'b0; m_udf = 1'b0;
      end else begin
         full   = (mq.size() == DEPTH);
         empty  = (mq.size() == 0);
         ovf_ev = w && full && !rd;
         udf_ev = rd && empty;
         if (rd && !empty) void'(mq.pop_front());
         if (w && !ovf_ev) mq.push_back(d);
         m_ovf = ovf_ev | (m_ovf & ~c);
         m_udf = udf_ev | (m_udf & ~c);
      end
      #1;
   endtask

   task automatic cmp(input string tag, input string ctx, input string sig, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s %s actual %0h expected %0h", tag, ctx, sig, act, exp);
      end
   endtask

   task automatic chk(input string ctx);
      int exp_head;
      exp_head = (mq.size() == 0) ? 0 : int'(mq[0]);
      cmp((mq.size() == 0) ? "R10" : "R2", ctx, "head_byte", int'(head_byte), exp_head);
      cmp("R3", ctx, "has_data", int'(has_data), int'(mq.size() != 0));
      cmp("R8", ctx, "level", int'(level), mq.size());
      cmp("R4", ctx, "ovf_flag", int'(ovf_flag), int'(m_ovf));
      cmp("R5", ctx, "udf_flag", int'(udf_flag), int'(m_udf));
   endtask

   task automatic do_reset();
      step(1'b1, 1'b0, 1'b0, '0, 1'b0);
      step(1'b0, 1'b0, 1'b0, '0, 1'b0);
   endtask

   initial begin : watchdog
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", WATCHDOG_CYCLES);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stimulus
      logic [15:0] lfsr;
      logic        w, r, c, x;
      // R1: reset state
      do_reset();
      chk("R1 after reset");

      // R2 / R10: prefetch into an empty queue, then fill
      chk("R10 empty head");
      for (int i = 0; i < DEPTH; i++) begin
         step(1'b0, 1'b0, 1'b1, DW'(8'hA0 + i), 1'b0);
         chk("R2 prefetch fill");
      end

      // Sweep every fill level with each operation, then drain.
      for (int lvl = 0; lvl <= DEPTH; lvl++) begin
         for (int op = 1; op <= 3; op++) begin
            do_reset();
            for (int i = 0; i < lvl; i++) step(1'b0, 1'b0, 1'b1, DW'(lvl * 16 + i), 1'b0);
            chk("R8 filled");
            step(1'b0, 1'b0, op[0], DW'(8'h5A + lvl), op[1]);
            if (op == 3 && lvl > 0) chk("R9 read+write");
            else if (op == 1 && lvl == DEPTH) chk("R4 write when full");
            else if (op[1] && lvl == 0) chk("R5 read when empty");
            else chk("R8 single op");
            for (int i = 0; i <= DEPTH; i++) begin
               step(1'b0, 1'b0, 1'b0, '0, 1'b1);
               chk("R2 drain order");
            end
         end
      end

      // R6 / R7: stickiness and clearing
      do_reset();
      for (int i = 0; i <= DEPTH; i++) step(1'b0, 1'b0, 1'b1, DW'(8'h30 + i), 1'b0);
      for (int i = 0; i < 3; i++) begin
         step(1'b0, 1'b0, 1'b0, '0, 1'b0);
         chk("R6 overflow sticky");
      end
      step(1'b0, 1'b1, 1'b1, 8'hEE, 1'b0);
      chk("R6 clear with new overflow");
      step(1'b0, 1'b1, 1'b0, '0, 1'b0);
      chk("R7 clear keeps data");
      for (int i = 0; i <= DEPTH; i++) step(1'b0, 1'b0, 1'b0, '0, 1'b1);
      chk("R6 underflow set");
      step(1'b0, 1'b0, 1'b1, 8'h77, 1'b1);
      chk("R5 underflow with write");
      step(1'b0, 1'b1, 1'b0, '0, 1'b0);
      chk("R7 clear keeps head");

      // Mixed pseudo-random traffic
      do_reset();
      lfsr = 16'hACE1;
      for (int n = 0; n < 3000; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (n < 1500) begin
            w = lfsr[0]; r = lfsr[1] & lfsr[2];
         end else begin
            w = lfsr[0] & lfsr[2]; r = lfsr[1];
         end
         c = (lfsr[7:3] == 5'd0);
         x = (lfsr[15:9] == 7'd0);
         step(x, c, w, lfsr[11:4], r);
         chk("R3 mixed traffic");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule